// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Triggers

This block controls up to 32 general-purpose pins from a simple register port. Every pin has a direction bit, an output level and an interrupt detector. The detector can be configured, pin by pin, to fire on a high level, a low level, a rising transition, a falling transition, or on both transitions. Pad inputs pass through a two-stage synchronizer before any detection or readback.

A detected event sets a latched status bit for that pin. Software acknowledges it by writing ones to a clear register. An enable mask filters the status bits into a pending view, and a single interrupt line is raised whenever any pending bit is set.

The register port takes a word index, a write strobe and write data, and it returns read data combinationally. The word index is the byte offset divided by four. A read-only version word, fixed by a parameter, tells software whether the both-transitions register exists.

Top module: `pin_ctrl_irq`

## Requirements
- R1: After reset, the direction word (index 1) reads all ones across the active pins, so every pin is an input. The enable word (index 2) reads zero, and the version word (index 8) reads the VERSION parameter.
- R2: A direction bit of 1 turns that pin's output enable off. A bit of 0 turns it on and drives the pin with the matching bit of the level word (index 0).
- R3: A read of the level word (index 0) returns the pad level of every pin through two synchronizing flops. A pad change is not visible one cycle after the change and is visible two cycles after it.
- R4: When a pin's trigger-kind bit (index 6) is 0, the pin is level-triggered. Its polarity bit (index 7) set to 1 makes high the active level, and 0 makes low the active level. The status bit (index 3) is set while the active level persists, including right after a clear.
- R5: When a pin's trigger-kind bit is 1 and its both-transitions bit is 0, a polarity bit of 1 latches on a rising transition and 0 latches on a falling transition. Each transition latches exactly once.
- R6: When VERSION is 3 or more and both the trigger-kind bit and the both-transitions bit (index 9) are 1, either transition latches the status bit. The both-transitions word reads back what was written.
- R7: When VERSION is below 3, the both-transitions word reads zero, writes to it are ignored, and edge mode uses the polarity bit alone.
- R8: Writing the clear word (index 5) clears every status bit written as 1 and leaves every status bit written as 0 unchanged.
- R9: The pending word (index 4) is the status word ANDed with the enable word. The irq output is high exactly when some pending bit is set.
- R10: Writes to the version, status and pending words change nothing that can be read.
- R11: Bits at or above NUM_PINS read as zero in every word except the version word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_idx | input | 4 | Word index of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_idx, combinational |
| pad_in | input | NUM_PINS | Level seen at each pad |
| pad_out | output | NUM_PINS | Level driven on each pad |
| pad_oe | output | NUM_PINS | Output enable for each pad, 1 drives |
| irq | output | 1 | Combined interrupt, OR of all pending bits |

## Verification
The bench builds two instances. The first has eight pins and version 3, which is small enough to sweep every pin through both level polarities, both single-edge polarities and the both-transitions mode. It also exercises upper-bit masking, because 24 bits of every word lie above the pin count. The second has four pins and version 2, which brings within reach the variant without a both-transitions register: there, a falling edge on a rising-edge pin must leave no trace. The pads are looped back through the output enables, so readback of driven pins is seen at the ports.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int REG_W    = 32;
   localparam int MAX_PINS = 32;
   localparam int IDX_W    = 4;

   // Word indices (byte offset / 4); software depends on these positions.
   typedef enum logic [IDX_W-1:0] {
      IDX_LEVEL = 4'd0,
      IDX_DIR   = 4'd1,
      IDX_IEN   = 4'd2,
      IDX_STAT  = 4'd3,
      IDX_PEND  = 4'd4,
      IDX_CLR   = 4'd5,
      IDX_KIND  = 4'd6,
      IDX_POL   = 4'd7,
      IDX_VER   = 4'd8,
      IDX_BOTH  = 4'd9
   } reg_idx_e;

   // Version from which the both-transitions register is present.
   localparam int BOTH_MIN_VERSION = 3;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= d_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
   parameter int W        = 32,
   parameter bit HAS_BOTH = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] smp,
   input  logic [W-1:0] kind_edge,
   input  logic [W-1:0] pol_hi,
   input  logic [W-1:0] both_en,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] hit,
   output logic [W-1:0] status
);

   logic [W-1:0] prev_q;
   logic [W-1:0] stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= smp;
   end

   for (genvar i = 0; i < W; i++) begin : g_pin
      logic rise, fall, single, dual;
      assign rise   = smp[i] & ~prev_q[i];
      assign fall   = ~smp[i] & prev_q[i];
      assign single = pol_hi[i] ? rise : fall;
      if (HAS_BOTH) begin : g_both
         assign dual = both_en[i];
      end else begin : g_noboth
         assign dual = 1'b0;
      end
      always_comb begin
         if (kind_edge[i]) hit[i] = dual ? (rise | fall) : single;
         else              hit[i] = (smp[i] == pol_hi[i]);
      end
   end

   // Set has priority over clear so an ongoing level cannot be lost.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= hit | (stat_q & ~clr_mask);
   end

   assign status = stat_q;

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_irq_pkg::*;
#(
   parameter int W        = 32,
   parameter bit HAS_BOTH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic [W-1:0]     wdata,
   output logic [W-1:0]     dir_in,
   output logic [W-1:0]     lvl_out,
   output logic [W-1:0]     ien,
   output logic [W-1:0]     kind_edge,
   output logic [W-1:0]     pol_hi,
   output logic [W-1:0]     both_en,
   output logic [W-1:0]     clr_mask
);

   logic [W-1:0] dir_q, lvl_q, ien_q, kind_q, pol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '1;
         lvl_q  <= '0;
         ien_q  <= '0;
         kind_q <= '0;
         pol_q  <= '0;
      end else if (wr) begin
         case (idx)
            IDX_DIR:   dir_q  <= wdata;
            IDX_LEVEL: lvl_q  <= wdata;
            IDX_IEN:   ien_q  <= wdata;
            IDX_KIND:  kind_q <= wdata;
            IDX_POL:   pol_q  <= wdata;
            default: ;
         endcase
      end
   end

   if (HAS_BOTH) begin : g_both_reg
      logic [W-1:0] both_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      both_q <= '0;
         else if (wr && idx == IDX_BOTH)  both_q <= wdata;
      end
      assign both_en = both_q;
   end else begin : g_no_both
      assign both_en = '0;
   end

   assign clr_mask  = (wr && idx == IDX_CLR) ? wdata : '0;
   assign dir_in    = dir_q;
   assign lvl_out   = lvl_q;
   assign ien       = ien_q;
   assign kind_edge = kind_q;
   assign pol_hi    = pol_q;

endmodule

// File: rtl/pin_ctrl_irq.sv
module pin_ctrl_irq
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int VERSION     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [IDX_W-1:0]    reg_idx,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic                irq
);

   localparam bit HAS_BOTH = (VERSION >= BOTH_MIN_VERSION);

   if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
      $error("pin_ctrl_irq: NUM_PINS out of range");
   end
   if (VERSION < 0 || VERSION > 255) begin : g_bad_ver
      $error("pin_ctrl_irq: VERSION out of range");
   end

   logic [NUM_PINS-1:0] dir_in, lvl_out, ien_vec, kind_vec, pol_vec, both_vec;
   logic [NUM_PINS-1:0] clr_vec, smp_vec, hit_vec, status_vec, pend_vec;

   gpio_regs #(.W(NUM_PINS), .HAS_BOTH(HAS_BOTH)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .idx       (reg_idx),
      .wdata     (reg_wdata[NUM_PINS-1:0]),
      .dir_in    (dir_in),
      .lvl_out   (lvl_out),
      .ien       (ien_vec),
      .kind_edge (kind_vec),
      .pol_hi    (pol_vec),
      .both_en   (both_vec),
      .clr_mask  (clr_vec)
   );

   gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_in   (pad_in),
      .d_sync (smp_vec)
   );

   gpio_trig_detect #(.W(NUM_PINS), .HAS_BOTH(HAS_BOTH)) u_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp       (smp_vec),
      .kind_edge (kind_vec),
      .pol_hi    (pol_vec),
      .both_en   (both_vec),
      .clr_mask  (clr_vec),
      .hit       (hit_vec),
      .status    (status_vec)
   );

   assign pend_vec = status_vec & ien_vec;
   assign irq      = |pend_vec;
   assign pad_out  = lvl_out;
   assign pad_oe   = ~dir_in;

   always_comb begin
      reg_rdata = '0;
      case (reg_idx)
         IDX_LEVEL: reg_rdata[NUM_PINS-1:0] = smp_vec;
         IDX_DIR:   reg_rdata[NUM_PINS-1:0] = dir_in;
         IDX_IEN:   reg_rdata[NUM_PINS-1:0] = ien_vec;
         IDX_STAT:  reg_rdata[NUM_PINS-1:0] = status_vec;
         IDX_PEND:  reg_rdata[NUM_PINS-1:0] = pend_vec;
         IDX_KIND:  reg_rdata[NUM_PINS-1:0] = kind_vec;
         IDX_POL:   reg_rdata[NUM_PINS-1:0] = pol_vec;
         IDX_BOTH:  reg_rdata[NUM_PINS-1:0] = both_vec;
         IDX_VER:   reg_rdata = REG_W'(VERSION);
         default:   reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/pin_ctrl_irq_chk.sv
module pin_ctrl_irq_chk
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int VERSION  = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wr,
   input logic [IDX_W-1:0]    reg_idx,
   input logic [REG_W-1:0]    reg_wdata,
   input logic [REG_W-1:0]    reg_rdata,
   input logic                irq,
   input logic [NUM_PINS-1:0] status,
   input logic [NUM_PINS-1:0] hit,
   input logic [NUM_PINS-1:0] ien
);

   logic clr_wr;
   assign clr_wr = reg_wr && (reg_idx == IDX_CLR);

   // R8: bits written as 1 are gone next cycle unless re-hit
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((status & $past(reg_wdata[NUM_PINS-1:0] & ~hit)) == '0));

   // R8: without a clear write no status bit drops
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> ((status & $past(status)) == $past(status)));

   // R9: nothing enabled means no interrupt
   assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == '0) |-> !irq);

   // R9: interrupt needs some latched status
   assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status != '0));

   // R10: version word is fixed
   assert_ver_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_idx == IDX_VER) |-> (reg_rdata == REG_W'(VERSION)));

   // R11: bits above the pin count read zero
   assert_upper_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_idx != IDX_VER) |-> ((reg_rdata >> NUM_PINS) == '0));

endmodule

bind pin_ctrl_irq pin_ctrl_irq_chk #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_idx   (reg_idx),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq       (irq),
   .status    (status_vec),
   .hit       (hit_vec),
   .ien       (ien_vec)
);

// File: tb/pin_ctrl_irq_tb.sv
module pin_ctrl_irq_tb;
   import gpio_irq_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [IDX_W-1:0] idx = '0;
   logic [31:0] wdata = '0;
   logic wr_a = 1'b0, wr_b = 1'b0;
   logic [31:0] rdata_a, rdata_b;
   logic [7:0] ext_a = '0, out_a, oe_a, pin_a;
   logic [3:0] ext_b = '0, out_b, oe_b, pin_b;
   logic irq_a, irq_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   assign pin_a = (oe_a & out_a) | (~oe_a & ext_a);
   assign pin_b = (oe_b & out_b) | (~oe_b & ext_b);

   pin_ctrl_irq #(.NUM_PINS(8), .VERSION(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr_a), .reg_idx(idx), .reg_wdata(wdata),
      .reg_rdata(rdata_a), .pad_in(pin_a), .pad_out(out_a), .pad_oe(oe_a), .irq(irq_a));

   pin_ctrl_irq #(.NUM_PINS(4), .VERSION(2)) u_dut_v2 (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr_b), .reg_idx(idx), .reg_wdata(wdata),
      .reg_rdata(rdata_b), .pad_in(pin_b), .pad_out(out_b), .pad_oe(oe_b), .irq(irq_b));

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input bit b, input reg_idx_e r, input logic [31:0] d);
      @(negedge clk);
      idx = r; wdata = d;
      if (b) wr_b = 1'b1; else wr_a = 1'b1;
      @(negedge clk);
      wr_a = 1'b0; wr_b = 1'b0;
   endtask

   task automatic rd(input bit b, input reg_idx_e r, output logic [31:0] d);
      idx = r;
      #1;
      d = b ? rdata_b : rdata_a;
   endtask

   initial begin
      logic [31:0] v;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R1 reset state
      rd(0, IDX_DIR, v);  chk("R1 dir reset", v, 32'hFF);
      rd(0, IDX_IEN, v);  chk("R1 ien reset", v, 32'h0);
      rd(0, IDX_VER, v);  chk("R1 version", v, 32'd3);
      chk("R2 oe reset", {24'h0, oe_a}, 32'h0);

      // R2 direction and output drive
      wr(0, IDX_DIR, 32'hF0);
      wr(0, IDX_LEVEL, 32'h05);
      chk("R2 oe", {24'h0, oe_a}, 32'h0F);
      chk("R2 out", {28'h0, out_a[3:0]}, 32'h5);

      // R3 readback latency
      ext_a = 8'hA0;
      cyc(3);
      rd(0, IDX_LEVEL, v); chk("R3 level readback", v, 32'hA5);
      ext_a = 8'h50;
      cyc(1);
      rd(0, IDX_LEVEL, v); chk("R3 not yet visible", v, 32'hA5);
      cyc(1);
      rd(0, IDX_LEVEL, v); chk("R3 visible", v, 32'h55);

      wr(0, IDX_DIR, 32'hFF);

      // R4 level sweep, both polarities
      for (int p = 1; p >= 0; p--) begin
         wr(0, IDX_KIND, 32'h0);
         wr(0, IDX_POL, p ? 32'hFF : 32'h00);
         ext_a = p ? 8'h00 : 8'hFF;
         cyc(4);
         wr(0, IDX_CLR, 32'hFF);
         rd(0, IDX_STAT, v); chk("R4 idle", v, 32'h0);
         for (int i = 0; i < 8; i++) begin
            ext_a = p ? 8'(1 << i) : ~8'(1 << i);
            cyc(4);
            rd(0, IDX_STAT, v); chk("R4 level latch", v, 32'(1 << i));
            wr(0, IDX_CLR, 32'(1 << i));
            rd(0, IDX_STAT, v); chk("R4 persists after clear", v, 32'(1 << i));
            ext_a = p ? 8'h00 : 8'hFF;
            cyc(4);
            wr(0, IDX_CLR, 32'hFF);
            rd(0, IDX_STAT, v); chk("R4 released", v, 32'h0);
         end
      end

      // R5 single edge sweep: pins 0..3 rising, 4..7 falling
      wr(0, IDX_KIND, 32'hFF);
      wr(0, IDX_POL, 32'h0F);
      ext_a = 8'h00;
      cyc(4);
      wr(0, IDX_CLR, 32'hFF);
      for (int i = 0; i < 8; i++) begin
         ext_a = 8'(1 << i);
         cyc(4);
         rd(0, IDX_STAT, v); chk("R5 rise", v, (i < 4) ? 32'(1 << i) : 32'h0);
         wr(0, IDX_CLR, 32'hFF);
         cyc(3);
         rd(0, IDX_STAT, v); chk("R5 latched once", v, 32'h0);
         ext_a = 8'h00;
         cyc(4);
         rd(0, IDX_STAT, v); chk("R5 fall", v, (i >= 4) ? 32'(1 << i) : 32'h0);
         wr(0, IDX_CLR, 32'hFF);
      end

      // R6 both transitions
      wr(0, IDX_BOTH, 32'hFF);
      rd(0, IDX_BOTH, v); chk("R6 both readback", v, 32'hFF);
      for (int i = 0; i < 8; i++) begin
         ext_a = 8'(1 << i);
         cyc(4);
         rd(0, IDX_STAT, v); chk("R6 rise", v, 32'(1 << i));
         wr(0, IDX_CLR, 32'hFF);
         ext_a = 8'h00;
         cyc(4);
         rd(0, IDX_STAT, v); chk("R6 fall", v, 32'(1 << i));
         wr(0, IDX_CLR, 32'hFF);
      end
      wr(0, IDX_BOTH, 32'h0);

      // R8 partial clear
      wr(0, IDX_KIND, 32'h0);
      wr(0, IDX_POL, 32'hFF);
      ext_a = 8'hFF;
      cyc(4);
      ext_a = 8'h00;
      cyc(4);
      rd(0, IDX_STAT, v); chk("R8 all latched", v, 32'hFF);
      wr(0, IDX_CLR, 32'h0F);
      rd(0, IDX_STAT, v); chk("R8 zero bits kept", v, 32'hF0);

      // R9 pending and irq
      wr(0, IDX_IEN, 32'h30);
      rd(0, IDX_PEND, v); chk("R9 pending", v, 32'h30);
      chk("R9 irq high", {31'h0, irq_a}, 32'h1);
      wr(0, IDX_IEN, 32'h0F);
      rd(0, IDX_PEND, v); chk("R9 pending masked", v, 32'h0);
      chk("R9 irq low", {31'h0, irq_a}, 32'h0);
      wr(0, IDX_CLR, 32'hFF);
      wr(0, IDX_IEN, 32'hFF);
      chk("R9 irq low after clear", {31'h0, irq_a}, 32'h0);

      // R10 read-only words
      wr(0, IDX_VER, 32'h0);
      wr(0, IDX_STAT, 32'hFF);
      wr(0, IDX_PEND, 32'hFF);
      rd(0, IDX_VER, v);  chk("R10 version kept", v, 32'd3);
      rd(0, IDX_STAT, v); chk("R10 status kept", v, 32'h0);
      rd(0, IDX_PEND, v); chk("R10 pending kept", v, 32'h0);
      chk("R10 irq low", {31'h0, irq_a}, 32'h0);

      // R11 upper bits
      wr(0, IDX_IEN, 32'hFFFF_FFFF);
      rd(0, IDX_IEN, v); chk("R11 ien upper zero", v, 32'hFF);
      wr(0, IDX_POL, 32'hFFFF_FFFF);
      rd(0, IDX_POL, v); chk("R11 pol upper zero", v, 32'hFF);
      wr(0, IDX_IEN, 32'h0);

      // R7 version 2 instance
      rd(1, IDX_VER, v);  chk("R7 version", v, 32'd2);
      wr(1, IDX_BOTH, 32'hF);
      rd(1, IDX_BOTH, v); chk("R7 both reads zero", v, 32'h0);
      wr(1, IDX_KIND, 32'hF);
      wr(1, IDX_POL, 32'hF);
      ext_b = 4'h0;
      cyc(4);
      wr(1, IDX_CLR, 32'hF);
      ext_b = 4'h1;
      cyc(4);
      rd(1, IDX_STAT, v); chk("R7 rise latches", v, 32'h1);
      wr(1, IDX_CLR, 32'hF);
      ext_b = 4'h0;
      cyc(4);
      rd(1, IDX_STAT, v); chk("R7 fall ignored", v, 32'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule